// File: doc/BRIEF.md
# Bidirectional Parallel Port with Per-Pin Direction

This block is an eight-pin general-purpose port on a simple request/acknowledge bus. Software sees two registers at a pair of adjacent word addresses. The even word holds the output latch. The odd word holds a direction mask. Each pin has its own tri-state driver. When the pin's direction bit is set, the driver puts the latch bit on the pin. When the bit is clear, the driver releases the pin to high impedance.

Reading the even word returns the levels actually present on the pins, not the latch contents. Every pin is sampled through a chain of synchronizing flops before it reaches the read path. As a result, an output pin reads back the value it drives, and an input pin reads back whatever the outside world applies.

The bus uses a four-phase handshake:
- The master sets up address, direction and data, then raises the request (`bus_me`).
- The port answers by raising `bus_ack` and performs exactly one access.
- The master drops the request.
- The port then drops `bus_ack`.

Top module: `pport_dirctl`

## Requirements
- R1: After reset, both the latch and the direction mask are zero, so every pin is released. A later reset returns both registers to zero.
- R2: The port responds only when `bus_addr[29:1]` equals bit 29..1 of the base word address. Bit 0 selects the register: 0 for the latch, 1 for the direction mask. Any other address gets no acknowledge and changes no register.
- R3: `bus_ack` rises on the clock after a matching request is seen. It stays high while `bus_me` stays high, and falls on the clock after `bus_me` falls. Each request pulse performs exactly one access.
- R4: A write changes the selected register only when byte enable bit 0 is set. Otherwise the write is acknowledged and leaves both registers unchanged.
- R5: While direction bit i is 1, pin i carries latch bit i. While direction bit i is 0, pin i is left undriven (high impedance).
- R6: A read of the latch word returns the synchronized pin levels on data bits 7..0, with bits 31..8 zero.
- R7: A read of the direction word returns the direction mask on bits 7..0, with bits 31..8 zero.
- R8: `bus_rdata` is zero whenever `bus_ack` is low.
- R9: Pin levels pass through two flop stages before the read path. A pin change made in the same cycle that a read request is raised is not yet visible to that read.
- R10: Writing the latch while a pin is an input stores the value without disturbing the pin. The stored value appears on the pin once the pin's direction bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 30 | Word address |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_be | input | 4 | Byte enables; bit 0 covers data bits 7..0 |
| bus_wdata | input | 32 | Write data |
| bus_me | input | 1 | Request strobe |
| bus_ack | output | 1 | Acknowledge |
| bus_rdata | output | 32 | Read data, zero while not acknowledging |
| pin_io | inout | 8 | Port pins |

## Verification
The checker enforces the following on every clock:
- the handshake ordering of acknowledge against request;
- that the acknowledge is confined to the two mapped words;
- that the read bus is zero outside an acknowledge;
- that each output-enabled pin carries its latch bit;
- that a register changes only at an acknowledged write with lane 0 enabled.

Some behaviour is visible only through the bench scenarios:
- mixed-direction readback, where some pins are inputs and some are outputs;
- latch values held while the pins are inputs and released onto them later;
- the synchronizer delay on a fresh pin edge;
- restoration of the registers by a mid-run reset.

// File: rtl/pport_pkg.sv
package pport_pkg;

   // Register select, taken from the word-address LSB.
   typedef enum logic {
      PREG_LATCH = 1'b0,
      PREG_DIR   = 1'b1
   } preg_sel_e;

   // One decoded bus access, valid for the single strobe cycle.
   typedef struct packed {
      logic      wr;
      logic      rd;
      preg_sel_e sel;
      logic      lane_on;
   } pport_acc_t;

endpackage

// File: rtl/pport_handshake.sv
module pport_handshake
   import pport_pkg::*;
#(
   parameter int unsigned          AW        = 30,
   parameter int unsigned          BEW       = 4,
   parameter int unsigned          LANE      = 0,
   parameter logic [AW-1:0]        BASE_WORD = 30'h400_0018
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [AW-1:0]  addr,
   input  logic           rnw,
   input  logic [BEW-1:0] be,
   input  logic           me,
   output logic           ack,
   output logic           strobe,
   output pport_acc_t     acc
);
   localparam int unsigned PAIR_HI = AW - 1;

   logic match;
   logic ack_q;

   // The two registers share every address bit except bit 0.
   assign match  = (addr[PAIR_HI:1] == BASE_WORD[PAIR_HI:1]);
   assign strobe = me && match && !ack_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ack_q <= 1'b0;
      else if (strobe) ack_q <= 1'b1;
      else if (!me)    ack_q <= 1'b0;
   end

   always_comb begin
      acc.wr      = strobe && !rnw;
      acc.rd      = strobe && rnw;
      acc.sel     = preg_sel_e'(addr[0]);
      acc.lane_on = be[LANE];
   end

   assign ack = ack_q;
endmodule

// File: rtl/pport_regs.sv
module pport_regs
   import pport_pkg::*;
#(
   parameter int unsigned PW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  pport_acc_t    acc,
   input  logic [PW-1:0] wval,
   output logic [PW-1:0] latch_q,
   output logic [PW-1:0] dir_q
);
   logic wr_latch;
   logic wr_dir;

   assign wr_latch = acc.wr && acc.lane_on && (acc.sel == PREG_LATCH);
   assign wr_dir   = acc.wr && acc.lane_on && (acc.sel == PREG_DIR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        latch_q <= '0;
      else if (wr_latch) latch_q <= wval;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dir_q <= '0;
      else if (wr_dir) dir_q <= wval;
   end
endmodule

// File: rtl/pport_sync.sv
module pport_sync #(
   parameter int unsigned PW     = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] d,
   output logic [PW-1:0] q
);
   logic [PW-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= '0;
         else        stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/pport_pad.sv
module pport_pad #(
   parameter int unsigned PW = 8
) (
   input  logic [PW-1:0] drv_val,
   input  logic [PW-1:0] drv_en,
   output logic [PW-1:0] lvl,
   inout  wire  [PW-1:0] pin_io
);
   for (genvar i = 0; i < PW; i++) begin : g_pin
      assign pin_io[i] = drv_en[i] ? drv_val[i] : 1'bz;
      assign lvl[i]    = pin_io[i];
   end
endmodule

// File: rtl/pport_dirctl.sv
module pport_dirctl
   import pport_pkg::*;
#(
   parameter int unsigned   ADDR_W      = 30,
   parameter int unsigned   DATA_W      = 32,
   parameter int unsigned   PORT_W      = 8,
   parameter int unsigned   LANE        = 0,
   parameter int unsigned   SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] BASE_WORD = 30'h400_0018
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_rnw,
   input  logic [DATA_W/8-1:0] bus_be,
   input  logic [DATA_W-1:0]   bus_wdata,
   input  logic                bus_me,
   output logic                bus_ack,
   output logic [DATA_W-1:0]   bus_rdata,
   inout  wire  [PORT_W-1:0]   pin_io
);
   localparam int unsigned BEW    = DATA_W / 8;
   localparam int unsigned LANE_LO = LANE * 8;

   // Elaboration-time parameter checks
   if (PORT_W < 1 || PORT_W > 8) begin : g_bad_pw
      $error("PORT_W must be 1..8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (LANE >= BEW) begin : g_bad_lane
      $error("LANE outside the data bus");
   end
   if (BASE_WORD[0] != 1'b0) begin : g_bad_base
      $error("BASE_WORD must be even");
   end

   pport_acc_t        acc;
   logic              strobe;
   logic [PORT_W-1:0] latch_q;
   logic [PORT_W-1:0] dir_q;
   logic [PORT_W-1:0] pad_lvl;
   logic [PORT_W-1:0] pin_sync;
   logic [PORT_W-1:0] rd_val;
   logic [DATA_W-1:0] rd_word;
   logic [DATA_W-1:0] rdata_q;
   logic              unused_bus;

   assign unused_bus = ^{bus_wdata, bus_be};

   pport_handshake #(
      .AW(ADDR_W), .BEW(BEW), .LANE(LANE), .BASE_WORD(BASE_WORD)
   ) u_hs (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .rnw(bus_rnw),
      .be(bus_be), .me(bus_me), .ack(bus_ack), .strobe(strobe), .acc(acc)
   );

   pport_regs #(.PW(PORT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .acc(acc),
      .wval(bus_wdata[LANE_LO +: PORT_W]),
      .latch_q(latch_q), .dir_q(dir_q)
   );

   pport_pad #(.PW(PORT_W)) u_pad (
      .drv_val(latch_q), .drv_en(dir_q), .lvl(pad_lvl), .pin_io(pin_io)
   );

   pport_sync #(.PW(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_lvl), .q(pin_sync)
   );

   assign rd_val = (acc.sel == PREG_DIR) ? dir_q : pin_sync;

   always_comb begin
      rd_word = '0;
      rd_word[LANE_LO +: PORT_W] = rd_val;
   end

   // Read data is loaded on the strobe and cleared when the request drops.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                rdata_q <= '0;
      else if (acc.rd && strobe) rdata_q <= rd_word;
      else if (!bus_me)          rdata_q <= '0;
   end

   assign bus_rdata = rdata_q;
endmodule

// File: rtl/pport_dirctl_chk.sv
module pport_dirctl_chk #(
   parameter int unsigned       AW  = 30,
   parameter int unsigned       DW  = 32,
   parameter int unsigned       PW  = 8,
   parameter int unsigned       LN  = 0,
   parameter logic [AW-1:0]     BASE = 30'h400_0018
) (
   input logic            clk,
   input logic            rst_n,
   input logic [AW-1:0]   addr,
   input logic            rnw,
   input logic [DW/8-1:0] be,
   input logic            me,
   input logic            ack,
   input logic [DW-1:0]   rdata,
   input logic [PW-1:0]   latch_q,
   input logic [PW-1:0]   dir_q,
   input logic [PW-1:0]   pins
);
   // R2: acknowledge only for the mapped word pair
   a_r2_ack_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack) |-> ($past(addr[AW-1:1]) == BASE[AW-1:1]));

   // R3: acknowledge rises only in answer to a request
   a_r3_ack_follows_me: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack) |-> $past(me));

   // R3: acknowledge held while the request stays up
   a_r3_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && me) |=> ack);

   // R3: acknowledge released after the request drops
   a_r3_ack_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !me) |=> !ack);

   // R4: registers move only on an acknowledged write with the lane enabled
   a_r4_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !($stable(latch_q) && $stable(dir_q)) |->
         ($rose(ack) && !$past(rnw) && $past(be[LN])));

   // R5: each enabled pin carries its latch bit
   a_r5_pin_driven: assert property (@(posedge clk) disable iff (!rst_n)
      ((pins ^ latch_q) & dir_q) == '0);

   // R8: read bus idle outside an acknowledge
   a_r8_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !ack |-> (rdata == '0));
endmodule

bind pport_dirctl pport_dirctl_chk #(
   .AW(ADDR_W), .DW(DATA_W), .PW(PORT_W), .LN(LANE), .BASE(BASE_WORD)
) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(bus_addr), .rnw(bus_rnw), .be(bus_be),
   .me(bus_me), .ack(bus_ack), .rdata(bus_rdata), .latch_q(latch_q),
   .dir_q(dir_q), .pins(pin_io)
);

// File: tb/pport_dirctl_tb.sv
`timescale 1ns/1ps
module pport_dirctl_tb;
   localparam logic [29:0] BASE = 30'h400_0018;
   localparam int NV = 17;

   // {req[41:38], wr[37], dsel[36], be[35:32], wd[31:24], ext_en[23:16], ext_val[15:8], exp[7:0]}
   localparam logic [41:0] VEC [NV] = '{
      {4'd6,  1'b0, 1'b0, 4'h1, 8'h00, 8'hFF, 8'hA5, 8'hA5}, // R6 input readback
      {4'd7,  1'b0, 1'b1, 4'h1, 8'h00, 8'hFF, 8'hA5, 8'h00}, // R7 dir after reset
      {4'd10, 1'b1, 1'b0, 4'h1, 8'h3C, 8'hFF, 8'hA5, 8'h00}, // R10 latch while inputs
      {4'd10, 1'b0, 1'b0, 4'h1, 8'h00, 8'hFF, 8'h5A, 8'h5A}, // R10 pins unaffected
      {4'd5,  1'b1, 1'b1, 4'h1, 8'h0F, 8'hF0, 8'h50, 8'h00}, // R5 low nibble out
      {4'd7,  1'b0, 1'b1, 4'h1, 8'h00, 8'hF0, 8'h50, 8'h0F}, // R7
      {4'd5,  1'b0, 1'b0, 4'h1, 8'h00, 8'hF0, 8'h90, 8'h9C}, // R5 mixed readback
      {4'd4,  1'b1, 1'b1, 4'hE, 8'hFF, 8'hF0, 8'h90, 8'h00}, // R4 lane off
      {4'd4,  1'b0, 1'b1, 4'h1, 8'h00, 8'hF0, 8'h90, 8'h0F}, // R4
      {4'd4,  1'b1, 1'b0, 4'h2, 8'h77, 8'hF0, 8'h90, 8'h00}, // R4 lane off
      {4'd4,  1'b0, 1'b0, 4'h1, 8'h00, 8'hF0, 8'h90, 8'h9C}, // R4
      {4'd5,  1'b1, 1'b1, 4'h1, 8'hFF, 8'h00, 8'h00, 8'h00}, // R5 all out
      {4'd5,  1'b0, 1'b0, 4'h1, 8'h00, 8'h00, 8'h00, 8'h3C}, // R5
      {4'd5,  1'b1, 1'b0, 4'h1, 8'hC3, 8'h00, 8'h00, 8'h00}, // R5
      {4'd5,  1'b0, 1'b0, 4'h1, 8'h00, 8'h00, 8'h00, 8'hC3}, // R5
      {4'd6,  1'b1, 1'b1, 4'hF, 8'h00, 8'h00, 8'h00, 8'h00}, // R6 all in
      {4'd6,  1'b0, 1'b0, 4'h1, 8'h00, 8'hFF, 8'h81, 8'h81}  // R6
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [29:0] bus_addr = '0;
   logic        bus_rnw = 1'b1;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_me = 1'b0;
   logic        bus_ack;
   logic [31:0] bus_rdata;
   wire  [7:0]  pad;
   logic [7:0]  ext_en = '0;
   logic [7:0]  ext_val = '0;
   int          checks = 0;
   int          fails = 0;
   logic        done = 1'b0;

   always #2 clk = ~clk;

   for (genvar i = 0; i < 8; i++) begin : g_ext
      assign pad[i] = ext_en[i] ? ext_val[i] : 1'bz;
   end

   pport_dirctl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rnw(bus_rnw),
      .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_me(bus_me),
      .bus_ack(bus_ack), .bus_rdata(bus_rdata), .pin_io(pad)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Called at a negedge; returns at a negedge after the acknowledge drops.
   task automatic access(input logic [29:0] a, input logic wr, input logic [3:0] be,
                         input logic [7:0] wd, output logic [31:0] rd);
      bus_addr = a; bus_rnw = !wr; bus_be = be; bus_wdata = {24'hABCDEF, wd};
      bus_me = 1'b1;
      @(negedge clk);
      chk(bus_ack == 1'b1, "R3 ack rise", {31'd0, bus_ack}, 32'd1);
      rd = bus_rdata;
      @(negedge clk);
      chk(bus_ack == 1'b1, "R3 ack hold", {31'd0, bus_ack}, 32'd1);
      bus_me = 1'b0;
      @(negedge clk);
      chk(bus_ack == 1'b0, "R3 ack fall", {31'd0, bus_ack}, 32'd0);
      chk(bus_rdata == 32'd0, "R8 idle rdata", bus_rdata, 32'd0);
   endtask

   task automatic rd_chk(input logic dsel, input logic [7:0] exp, input string req);
      logic [31:0] r;
      access(BASE + {29'd0, dsel}, 1'b0, 4'h1, 8'h00, r);
      chk(r == {24'd0, exp}, req, r, {24'd0, exp});
   endtask

   task automatic wr_do(input logic dsel, input logic [3:0] be, input logic [7:0] wd);
      logic [31:0] r;
      access(BASE + {29'd0, dsel}, 1'b1, be, wd, r);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 / R8: reset state at the ports
      chk(bus_ack == 1'b0, "R1 ack after reset", {31'd0, bus_ack}, 32'd0);
      chk(bus_rdata == 32'd0, "R8 rdata after reset", bus_rdata, 32'd0);

      for (int k = 0; k < NV; k++) begin
         logic [41:0] v;
         logic [31:0] r;
         v = VEC[k];
         ext_en = v[23:16];
         ext_val = v[15:8];
         repeat (4) @(negedge clk);
         access(BASE + {29'd0, v[36]}, v[37], v[35:32], v[31:24], r);
         if (!v[37])
            chk(r == {24'd0, v[7:0]}, $sformatf("R%0d vector %0d", v[41:38], k),
                r, {24'd0, v[7:0]});
      end

      // R2: off-base request gets no acknowledge and changes nothing
      bus_addr = BASE + 30'd2; bus_rnw = 1'b0; bus_be = 4'hF;
      bus_wdata = 32'hFFFF_FFFF; bus_me = 1'b1;
      repeat (4) @(negedge clk);
      chk(bus_ack == 1'b0, "R2 no ack off base", {31'd0, bus_ack}, 32'd0);
      bus_me = 1'b0;
      @(negedge clk);
      rd_chk(1'b1, 8'h00, "R2 dir untouched");

      // R9: pin edge coincident with the read request is not yet seen
      ext_en = 8'hFF; ext_val = 8'h00;
      repeat (4) @(negedge clk);
      rd_chk(1'b0, 8'h00, "R9 settle low");
      ext_val = 8'hFF;
      rd_chk(1'b0, 8'h00, "R9 sync delay");
      repeat (2) @(negedge clk);
      rd_chk(1'b0, 8'hFF, "R9 after sync");

      // R1: mid-run reset clears the direction mask and the latch
      ext_en = 8'h00;
      @(negedge clk);
      wr_do(1'b0, 4'h1, 8'h5A);
      wr_do(1'b1, 4'h1, 8'hFF);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd_chk(1'b1, 8'h00, "R1 dir cleared");
      wr_do(1'b1, 4'h1, 8'hFF);
      repeat (4) @(negedge clk);
      rd_chk(1'b0, 8'h00, "R1 latch cleared");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule